// File: doc/BRIEF.md
# Configurable Down-Counting Timer

A memory-mapped timer that counts down by one on each prescaled step. The step comes from an external timing-reference enable pulse, sampled on the system clock. The reference is already selected before it reaches the block; at the fast reference it runs at about 1 MHz. Software selects several options: 16-bit or 32-bit counting, a divide-by-1, 16 or 256 prescaler, and one of three behaviours once the count reaches zero. Those behaviours are periodic reload, free-running wrap and one-shot stop.

A write to the load register sets both the reload value and the counter. A write to the background load register changes only the reload value, so the current period is left alone. When the count reaches zero, a raw interrupt flag sets. The interrupt output is that flag gated by the interrupt enable bit. Any write to the clear register drops the flag.

Top module: `dcount_timer`

## Requirements
- R1: After reset the control register reads 0x20, the reload value reads 0xFFFFFFFF, the value register reads 0x0000FFFF (all ones at 16-bit width), and the raw flag, the masked flag and irq_o are 0.
- R2: Byte offsets: 0x00 reload value (load), 0x04 current value, 0x08 control, 0x0C interrupt clear, 0x10 raw flag in bit 0, 0x14 masked flag in bit 0, 0x18 background load. Control fields: bit 0 one-shot, bit 1 32-bit width, bits [3:2] prescale, bit 5 interrupt enable, bit 6 periodic, bit 7 timer enable. All other control bits read 0. Writes to 0x04, 0x10 and 0x14 have no effect.
- R3: A write to 0x00 sets the reload value, loads the counter in the next cycle and restarts the prescaler.
- R4: A write to 0x18 sets the reload value and leaves the current count unchanged.
- R5: The count decreases by one per prescaled step while bit 7 is set. It holds while bit 7 is clear.
- R6: Prescale code 00 steps on every reference pulse, 01 on every 16th pulse, and 10 or 11 on every 256th pulse, counted from the last load write.
- R7: A step that takes the count from 1 to 0 sets the raw flag.
- R8: In periodic mode (bit 6 set, bit 0 clear), a step at zero reloads the reload value.
- R9: In free-running mode (bits 6 and 0 clear), a step at zero sets the count to all ones at the selected width.
- R10: In one-shot mode (bit 0 set, which overrides bit 6), the count stays at zero until the next load write.
- R11: In 16-bit mode only the low 16 bits count and are tested for zero. The value register reads with bits [31:16] zero.
- R12: Any write to 0x0C clears the raw flag. If a set and a clear fall in the same cycle, the set wins.
- R13: The masked flag and irq_o equal the raw flag AND control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing-reference enable pulse, one clock wide per reference edge |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Masked interrupt |

## Verification
The properties assume two things about the inputs: tick_i is a clean single-cycle pulse that is sampled only at clock edges, and each register write is one cycle long with a stable address. The hold and stability properties also assume that no load write lands in the cycle they observe, and their antecedents exclude that case. The stimulus drives every strobe and pulse on the falling edge and holds it for whole cycles. Reference pulses are issued only in runs of a known length, so the expected count after each run follows directly from the prescale setting. Same-cycle collisions are produced on purpose only in the directed set-versus-clear test.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W   = 32;
  localparam int NARROW_W = 16;
  localparam int ADDR_W   = 5;

  localparam logic [2:0] SEL_LOAD  = 3'd0;
  localparam logic [2:0] SEL_VALUE = 3'd1;
  localparam logic [2:0] SEL_CTRL  = 3'd2;
  localparam logic [2:0] SEL_CLR   = 3'd3;
  localparam logic [2:0] SEL_RAW   = 3'd4;
  localparam logic [2:0] SEL_MASK  = 3'd5;
  localparam logic [2:0] SEL_BGLD  = 3'd6;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       ie;
    logic       rsv;
    logic [1:0] pre;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 8'h20;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;
  logic             hit;

  always_comb begin
    unique case (sel_i)
      2'b00:   mask = '0;
      2'b01:   mask = PRE_W'(15);
      default: mask = '1;
    endcase
  end

  assign hit    = (cnt_q & mask) == mask;
  assign step_o = run_i & tick_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (tick_i)              cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W  = 32,
  parameter int NW = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  ctrl_t        ctrl_i,
  input  logic         load_wr_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         raw_set_o
);
  logic [W-1:0] cnt_q, cur, dec, wrap;

  assign cur  = ctrl_i.wide ? cnt_q : {{(W-NW){1'b0}}, cnt_q[NW-1:0]};
  assign dec  = ctrl_i.wide ? cnt_q - 1'b1 : {cnt_q[W-1:NW], cnt_q[NW-1:0] - 1'b1};
  assign wrap = ctrl_i.wide ? '1 : {cnt_q[W-1:NW], {NW{1'b1}}};

  assign raw_set_o = step_i & ctrl_i.en & !load_wr_i & (cur == W'(1));
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else if (load_wr_i) cnt_q <= load_val_i;
    else if (step_i && ctrl_i.en) begin
      if (cur != '0)            cnt_q <= dec;
      else if (ctrl_i.oneshot)  cnt_q <= cnt_q;
      else if (ctrl_i.periodic) cnt_q <= reload_i;
      else                      cnt_q <= wrap;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W  = 32,
  parameter int NW = 16,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  count_i,
  input  logic          raw_set_i,
  output ctrl_t         ctrl_o,
  output logic [W-1:0]  reload_o,
  output logic          raw_o,
  output logic          load_wr_o,
  output logic [W-1:0]  rdata_o
);
  logic [2:0] sel;
  logic       in_range, clr_wr;
  ctrl_t      ctrl_q;
  logic [W-1:0] reload_q;
  logic       raw_q;

  assign sel       = addr_i[4:2];
  assign in_range  = (addr_i[1:0] == 2'b00);
  assign load_wr_o = wr_en_i & in_range & (sel == SEL_LOAD);
  assign clr_wr    = wr_en_i & in_range & (sel == SEL_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      reload_q <= '1;
    end else if (wr_en_i && in_range) begin
      if (sel == SEL_LOAD || sel == SEL_BGLD) reload_q <= wdata_i;
      if (sel == SEL_CTRL) begin
        ctrl_q     <= ctrl_t'(wdata_i[7:0]);
        ctrl_q.rsv <= 1'b0;
      end
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        raw_q <= 1'b0;
    else if (raw_set_i) raw_q <= 1'b1;
    else if (clr_wr)    raw_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (in_range) begin
      unique case (sel)
        SEL_LOAD, SEL_BGLD: rdata_o = reload_q;
        SEL_VALUE: rdata_o = ctrl_q.wide ? count_i : {{(W-NW){1'b0}}, count_i[NW-1:0]};
        SEL_CTRL:  rdata_o = W'(ctrl_q);
        SEL_RAW:   rdata_o = W'(raw_q);
        SEL_MASK:  rdata_o = W'(raw_q & ctrl_q.ie);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign raw_o    = raw_q;
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import tmr_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int NW    = NARROW_W,
  parameter int AW    = ADDR_W,
  parameter int PRE_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          irq_o
);
  ctrl_t        ctrl;
  logic [W-1:0] reload, count;
  logic         raw, raw_set, load_wr, step;

  tmr_regs #(.W(W), .NW(NW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .count_i(count), .raw_set_i(raw_set),
    .ctrl_o(ctrl), .reload_o(reload), .raw_o(raw),
    .load_wr_o(load_wr), .rdata_o
  );

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .tick_i, .run_i(ctrl.en),
    .restart_i(load_wr), .sel_i(ctrl.pre), .step_o(step)
  );

  tmr_counter #(.W(W), .NW(NW)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .ctrl_i(ctrl),
    .load_wr_i(load_wr), .load_val_i(wdata_i), .reload_i(reload),
    .count_o(count), .raw_set_o(raw_set)
  );

  assign irq_o = raw & ctrl.ie;
endmodule

// File: rtl/dcount_timer_chk.sv
module dcount_timer_chk
  import tmr_pkg::*;
#(
  parameter int W  = 32,
  parameter int NW = 16,
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  rdata_o,
  input logic          irq_o,
  input ctrl_t         ctrl,
  input logic [W-1:0]  count,
  input logic          raw,
  input logic          step
);
  logic ld_w, bg_w, clr_w;
  logic [W-1:0] cur;
  assign ld_w  = wr_en_i && addr_i == AW'(8'h00);
  assign bg_w  = wr_en_i && addr_i == AW'(8'h18);
  assign clr_w = wr_en_i && addr_i == AW'(8'h0C);
  assign cur   = ctrl.wide ? count : {{(W-NW){1'b0}}, count[NW-1:0]};

  // R3
  load_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_w |=> count == $past(wdata_i));
  // R4
  bg_keeps_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_w && !step |=> $stable(count));
  // R5
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en && !ld_w |=> $stable(count));
  // R10
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.en && ctrl.oneshot && cur == '0 && !ld_w && !(wr_en_i && addr_i == AW'(8'h08)) |=> cur == '0);
  // R11
  narrow_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.wide && addr_i == AW'(8'h04) |-> rdata_o[W-1:NW] == '0);
  // R12
  clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w && !tick_i |=> !raw);
  // R13
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl.ie && raw);
endmodule

bind dcount_timer dcount_timer_chk #(.W(W), .NW(NW), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .tick_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .irq_o,
  .ctrl, .count, .raw, .step
);

// File: tb/dcount_timer_test.sv
module dcount_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  dcount_timer uut (.*);

  localparam logic [1:0] WR = 2'd0, RD = 2'd1, TK = 2'd2, IQ = 2'd3;
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;
  localparam int NV = 62;
  localparam vec_t VEC [NV] = '{
    '{RD, 4'd1,  5'h08, 32'h0, 32'h20},        // R1
    '{RD, 4'd1,  5'h04, 32'h0, 32'h0000FFFF},  // R1
    '{RD, 4'd1,  5'h00, 32'h0, 32'hFFFFFFFF},  // R1
    '{RD, 4'd1,  5'h10, 32'h0, 32'h0},         // R1
    '{IQ, 4'd1,  5'h00, 32'h0, 32'h0},         // R1
    '{WR, 4'd2,  5'h08, 32'hFFFFFFE2, 32'h0},
    '{RD, 4'd2,  5'h08, 32'h0, 32'hE2},        // R2 reserved bits read 0
    '{WR, 4'd3,  5'h00, 32'h3, 32'h0},
    '{RD, 4'd3,  5'h04, 32'h0, 32'h3},         // R3
    '{TK, 4'd5,  5'h00, 32'd1, 32'h0},
    '{RD, 4'd5,  5'h04, 32'h0, 32'h2},         // R5
    '{TK, 4'd7,  5'h00, 32'd2, 32'h0},
    '{RD, 4'd7,  5'h04, 32'h0, 32'h0},         // R7
    '{RD, 4'd7,  5'h10, 32'h0, 32'h1},         // R7
    '{RD, 4'd13, 5'h14, 32'h0, 32'h1},         // R13
    '{IQ, 4'd13, 5'h00, 32'h0, 32'h1},         // R13
    '{TK, 4'd8,  5'h00, 32'd1, 32'h0},
    '{RD, 4'd8,  5'h04, 32'h0, 32'h3},         // R8
    '{WR, 4'd2,  5'h10, 32'h0, 32'h0},
    '{RD, 4'd2,  5'h10, 32'h0, 32'h1},         // R2 raw write ignored
    '{WR, 4'd12, 5'h0C, 32'h0, 32'h0},
    '{RD, 4'd12, 5'h10, 32'h0, 32'h0},         // R12
    '{WR, 4'd2,  5'h04, 32'h55, 32'h0},
    '{RD, 4'd2,  5'h04, 32'h0, 32'h3},         // R2 value write ignored
    '{WR, 4'd4,  5'h18, 32'hA, 32'h0},
    '{RD, 4'd4,  5'h04, 32'h0, 32'h3},         // R4
    '{RD, 4'd4,  5'h00, 32'h0, 32'hA},         // R4
    '{TK, 4'd8,  5'h00, 32'd4, 32'h0},
    '{RD, 4'd8,  5'h04, 32'h0, 32'hA},         // R8 uses background value
    '{WR, 4'd9,  5'h08, 32'hA2, 32'h0},
    '{WR, 4'd9,  5'h00, 32'h1, 32'h0},
    '{TK, 4'd9,  5'h00, 32'd2, 32'h0},
    '{RD, 4'd9,  5'h04, 32'h0, 32'hFFFFFFFF},  // R9 32-bit
    '{WR, 4'd11, 5'h08, 32'hA0, 32'h0},
    '{WR, 4'd11, 5'h00, 32'h00030001, 32'h0},
    '{RD, 4'd11, 5'h04, 32'h0, 32'h1},         // R11
    '{WR, 4'd12, 5'h0C, 32'h0, 32'h0},
    '{TK, 4'd11, 5'h00, 32'd1, 32'h0},
    '{RD, 4'd11, 5'h10, 32'h0, 32'h1},         // R11 low half zero
    '{TK, 4'd9,  5'h00, 32'd1, 32'h0},
    '{RD, 4'd9,  5'h04, 32'h0, 32'h0000FFFF},  // R9 16-bit
    '{WR, 4'd10, 5'h08, 32'hE3, 32'h0},
    '{WR, 4'd10, 5'h00, 32'h2, 32'h0},
    '{TK, 4'd10, 5'h00, 32'd5, 32'h0},
    '{RD, 4'd10, 5'h04, 32'h0, 32'h0},         // R10
    '{WR, 4'd13, 5'h08, 32'h83, 32'h0},
    '{RD, 4'd13, 5'h14, 32'h0, 32'h0},         // R13
    '{IQ, 4'd13, 5'h00, 32'h0, 32'h0},         // R13
    '{WR, 4'd6,  5'h08, 32'hC6, 32'h0},
    '{WR, 4'd6,  5'h00, 32'h5, 32'h0},
    '{TK, 4'd6,  5'h00, 32'd15, 32'h0},
    '{RD, 4'd6,  5'h04, 32'h0, 32'h5},         // R6 div16
    '{TK, 4'd6,  5'h00, 32'd1, 32'h0},
    '{RD, 4'd6,  5'h04, 32'h0, 32'h4},         // R6 div16
    '{WR, 4'd6,  5'h08, 32'hCE, 32'h0},
    '{WR, 4'd6,  5'h00, 32'h5, 32'h0},
    '{TK, 4'd6,  5'h00, 32'd255, 32'h0},
    '{RD, 4'd6,  5'h04, 32'h0, 32'h5},         // R6 div256
    '{TK, 4'd6,  5'h00, 32'd1, 32'h0},
    '{RD, 4'd6,  5'h04, 32'h0, 32'h4},         // R6 div256
    '{WR, 4'd5,  5'h08, 32'h46, 32'h0},
    '{TK, 4'd5,  5'h00, 32'd7, 32'h0}
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1 check(req, rdata_o, exp);
  endtask

  task automatic tk(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      unique case (VEC[i].op)
        WR: wr(VEC[i].addr, VEC[i].data);
        RD: rd(int'(VEC[i].req), VEC[i].addr, VEC[i].exp);
        TK: tk(int'(VEC[i].data));
        default: begin
          @(negedge clk_i);
          check(int'(VEC[i].req), {31'b0, irq_o}, VEC[i].exp);
        end
      endcase
    end
    // R5: timer disabled above, count held
    rd(5, 5'h04, 32'h4);

    // R12: set and clear in the same cycle, set wins
    wr(5'h08, 32'hE2);
    wr(5'h00, 32'h1);
    wr(5'h0C, 32'h0);
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 5'h0C;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rd(12, 5'h10, 32'h1);
    @(negedge clk_i);
    check(13, {31'b0, irq_o}, 32'h1);  // R13

    // R1: reset in mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(1, 5'h08, 32'h20);
    rd(1, 5'h04, 32'h0000FFFF);
    rd(1, 5'h18, 32'hFFFFFFFF);
    rd(1, 5'h10, 32'h0);
    @(negedge clk_i);
    check(1, {31'b0, irq_o}, 32'h0);

    summary();
    $finish;
  end
endmodule